// File: doc/BRIEF.md
# Serial Signaling Bus Port for Fractional E1

This block links a bit-serial signaling line to an E1 framer working in fractional mode. It keeps the channel and bit position inside the 32-channel frame, realigned by a frame-start pulse. On the transmit side it picks the four signaling bits of each channel (A, B, C, D) off a serial input during the last four bit times of that channel's PCM octet, and presents them as a parallel nibble with a one-cycle valid strobe.

On the receive side it takes the parallel nibble that the framer supplies for the channel currently on the line. It places the bits on a serial output in the same four bit times and holds the line low for the rest of the octet. The current channel number and bit position are outputs, so the framer knows which nibble to present.

When fractional mode is off, the serial output goes back to marking channel boundaries and no nibbles are captured. Multiframe assembly and signaling storage belong to neighbouring blocks.

Top module: `sigbus_port`

## Requirements
- R1: While reset is held, and in the first cycle after release, `ch_idx` and `bit_idx` are 0 and `tx_nib_vld` is 0.
- R2: Without a frame start, `bit_idx` (0 stands for PCM bit 1, the MSB, and 7 for bit 8, the LSB) rises by one each cycle. After 7 it returns to 0 and `ch_idx` rises by one, going from 31 back to 0.
- R3: In a cycle with `frame_start` high, `ch_idx` and `bit_idx` both read 0.
- R4: With `frac_en` high, the serial input sampled at bit positions 4, 5, 6, 7 (PCM bits 5 to 8) becomes `tx_nib[3]` (A), `tx_nib[2]` (B), `tx_nib[1]` (C) and `tx_nib[0]` (D). `tx_nib_vld` is high for exactly the one cycle after bit position 7, and `tx_nib_ch` then gives that channel.
- R5: Values on `tx_sig_in` during bit positions 0 to 3 have no effect on any captured nibble.
- R6: With `frac_en` high, `rx_sig_out` is low during bit positions 0 to 3.
- R7: With `frac_en` high, `rx_sig_out` carries `rx_nib_in[3]`, `[2]`, `[1]`, `[0]` during bit positions 4, 5, 6, 7 respectively.
- R8: A frame start arriving inside a channel's octet abandons that channel's partial nibble: no strobe is produced for it, and capture resumes with channel 0.
- R9: With `frac_en` low, `tx_nib_vld` stays low and `rx_sig_out` is high exactly during bit position 0 of every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frac_en | input | 1 | Fractional mode enable; low selects channel-marker role |
| frame_start | input | 1 | Marks bit position 0 of channel 0 in this cycle |
| tx_sig_in | input | 1 | Serial signaling from external equipment |
| rx_nib_in | input | 4 | A,B,C,D (bit 3 to 0) for the channel on `ch_idx` |
| ch_idx | output | 5 | Channel in the current bit time |
| bit_idx | output | 3 | Bit position in the current octet, 0 = MSB |
| tx_nib | output | 4 | Captured A,B,C,D, held between strobes |
| tx_nib_ch | output | 5 | Channel of `tx_nib` |
| tx_nib_vld | output | 1 | One-cycle strobe for a new captured nibble |
| rx_sig_out | output | 1 | Serial signaling output or channel marker |

## Verification
The hardest case to reach from the ports is a frame start that lands inside the signaling window of a channel, after some of its bits are already accumulated. The stimulus runs clean frames first and then places a frame start at bit position 5 of channel 5. The bench expects no strobe for that channel and a correct channel-0 nibble afterwards. The bit times ignored on transmit carry the inverted nibble, so any leak of those bits into a capture shows up. Mode is also dropped and restored in the middle of an octet.

// File: rtl/sigbus_pkg.sv
package sigbus_pkg;

  // True when an octet position falls in the trailing signaling window.
  function automatic bit in_sig_window(input int pos, input int oct_bits, input int sig_bits);
    return (pos >= oct_bits - sig_bits) && (pos < oct_bits);
  endfunction

  // Nibble bit carried at an octet position (A is the nibble MSB).
  function automatic int sig_index(input int pos, input int oct_bits);
    return oct_bits - 1 - pos;
  endfunction

  // Channel that follows a given one, wrapping at the frame end.
  function automatic int next_channel(input int ch, input int num_ch);
    return (ch == num_ch - 1) ? 0 : ch + 1;
  endfunction

endpackage

// File: rtl/sigbus_timer.sv
module sigbus_timer #(
  parameter int NUM_CH   = 32,
  parameter int OCT_BITS = 8,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int POS_W   = $clog2(OCT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  output logic [POS_W-1:0] cur_pos,
  output logic [CH_W-1:0]  cur_ch,
  output logic             oct_last
);
  import sigbus_pkg::*;

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(OCT_BITS - 1);

  logic [POS_W-1:0] pos_q;
  logic [CH_W-1:0]  ch_q;

  assign cur_pos  = frame_start ? '0 : pos_q;
  assign cur_ch   = frame_start ? '0 : ch_q;
  assign oct_last = (cur_pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      ch_q  <= '0;
    end else if (oct_last) begin
      pos_q <= '0;
      ch_q  <= CH_W'(next_channel(int'(cur_ch), NUM_CH));
    end else begin
      pos_q <= cur_pos + 1'b1;
      ch_q  <= cur_ch;
    end
  end

endmodule

// File: rtl/sigbus_capture.sv
module sigbus_capture #(
  parameter int CH_W     = 5,
  parameter int POS_W    = 3,
  parameter int OCT_BITS = 8,
  parameter int SIG_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [POS_W-1:0]    cur_pos,
  input  logic [CH_W-1:0]     cur_ch,
  input  logic                oct_last,
  input  logic                sig_in,
  output logic [SIG_BITS-1:0] nib,
  output logic [CH_W-1:0]     nib_ch,
  output logic                nib_vld
);
  import sigbus_pkg::*;

  localparam logic [POS_W-1:0] FIRST_POS = POS_W'(OCT_BITS - SIG_BITS);

  logic [SIG_BITS-1:0] acc_q;
  logic                win;
  logic                win_first;
  logic [SIG_BITS-1:0] acc_next;

  assign win       = in_sig_window(int'(cur_pos), OCT_BITS, SIG_BITS);
  assign win_first = (cur_pos == FIRST_POS);
  // First window bit starts a fresh nibble, dropping any stale partial bits.
  assign acc_next  = win_first ? {{(SIG_BITS-1){1'b0}}, sig_in}
                               : {acc_q[SIG_BITS-2:0], sig_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      nib     <= '0;
      nib_ch  <= '0;
      nib_vld <= 1'b0;
    end else begin
      if (win) acc_q <= acc_next;
      nib_vld <= en && oct_last;
      if (en && oct_last) begin
        nib    <= acc_next;
        nib_ch <= cur_ch;
      end
    end
  end

endmodule

// File: rtl/sigbus_drive.sv
module sigbus_drive #(
  parameter int POS_W    = 3,
  parameter int OCT_BITS = 8,
  parameter int SIG_BITS = 4
) (
  input  logic                en,
  input  logic [POS_W-1:0]    cur_pos,
  input  logic [SIG_BITS-1:0] nib_in,
  output logic                ser_out
);
  import sigbus_pkg::*;

  localparam int IDX_W = (SIG_BITS > 1) ? $clog2(SIG_BITS) : 1;

  logic             win;
  logic [IDX_W-1:0] idx;

  assign win = in_sig_window(int'(cur_pos), OCT_BITS, SIG_BITS);
  assign idx = IDX_W'(sig_index(int'(cur_pos), OCT_BITS));

  always_comb begin
    if (!en)      ser_out = (cur_pos == '0);
    else if (win) ser_out = nib_in[idx];
    else          ser_out = 1'b0;
  end

endmodule

// File: rtl/sigbus_port.sv
module sigbus_port #(
  parameter int NUM_CH   = 32,
  parameter int OCT_BITS = 8,
  parameter int SIG_BITS = 4,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int POS_W   = $clog2(OCT_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frac_en,
  input  logic                frame_start,
  input  logic                tx_sig_in,
  input  logic [SIG_BITS-1:0] rx_nib_in,
  output logic [CH_W-1:0]     ch_idx,
  output logic [POS_W-1:0]    bit_idx,
  output logic [SIG_BITS-1:0] tx_nib,
  output logic [CH_W-1:0]     tx_nib_ch,
  output logic                tx_nib_vld,
  output logic                rx_sig_out
);

  logic oct_last;

  sigbus_timer #(.NUM_CH(NUM_CH), .OCT_BITS(OCT_BITS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .cur_pos    (bit_idx),
    .cur_ch     (ch_idx),
    .oct_last   (oct_last)
  );

  sigbus_capture #(.CH_W(CH_W), .POS_W(POS_W), .OCT_BITS(OCT_BITS), .SIG_BITS(SIG_BITS)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (frac_en),
    .cur_pos (bit_idx),
    .cur_ch  (ch_idx),
    .oct_last(oct_last),
    .sig_in  (tx_sig_in),
    .nib     (tx_nib),
    .nib_ch  (tx_nib_ch),
    .nib_vld (tx_nib_vld)
  );

  sigbus_drive #(.POS_W(POS_W), .OCT_BITS(OCT_BITS), .SIG_BITS(SIG_BITS)) u_drive (
    .en     (frac_en),
    .cur_pos(bit_idx),
    .nib_in (rx_nib_in),
    .ser_out(rx_sig_out)
  );

endmodule

// File: rtl/sigbus_port_chk.sv
module sigbus_port_chk #(
  parameter int NUM_CH   = 32,
  parameter int OCT_BITS = 8,
  parameter int SIG_BITS = 4,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int POS_W   = $clog2(OCT_BITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frac_en,
  input logic             frame_start,
  input logic [CH_W-1:0]  ch_idx,
  input logic [POS_W-1:0] bit_idx,
  input logic [CH_W-1:0]  tx_nib_ch,
  input logic             tx_nib_vld,
  input logic             rx_sig_out,
  input logic             oct_last
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(OCT_BITS - 1);
  localparam logic [POS_W-1:0] WIN_POS  = POS_W'(OCT_BITS - SIG_BITS);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

  assert_step_in_octet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !frame_start && $past(bit_idx) != LAST_POS)
      |-> (bit_idx == POS_W'($past(bit_idx) + 1'b1)) && (ch_idx == $past(ch_idx)));

  assert_channel_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !frame_start && $past(oct_last))
      |-> (bit_idx == '0) &&
          (ch_idx == (($past(ch_idx) == LAST_CH) ? '0 : CH_W'($past(ch_idx) + 1'b1))));

  assert_frame_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bit_idx == '0) && (ch_idx == '0));

  assert_strobe_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nib_vld |-> ($past(bit_idx) == LAST_POS) && (tx_nib_ch == $past(ch_idx)));

  assert_quiet_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_en && bit_idx < WIN_POS) |-> !rx_sig_out);

  assert_no_strobe_after_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(frame_start)) |-> !tx_nib_vld);

  assert_disabled_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(frac_en)) |-> !tx_nib_vld);

  assert_disabled_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frac_en |-> (rx_sig_out == (bit_idx == '0)));

endmodule

bind sigbus_port sigbus_port_chk #(.NUM_CH(NUM_CH), .OCT_BITS(OCT_BITS), .SIG_BITS(SIG_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frac_en    (frac_en),
  .frame_start(frame_start),
  .ch_idx     (ch_idx),
  .bit_idx    (bit_idx),
  .tx_nib_ch  (tx_nib_ch),
  .tx_nib_vld (tx_nib_vld),
  .rx_sig_out (rx_sig_out),
  .oct_last   (oct_last)
);

// File: tb/sigbus_port_bench.sv
`timescale 1ns/1ps
module sigbus_port_bench;
  logic       clk = 1'b0;
  logic       rst_n, frac_en, frame_start, tx_sig_in;
  logic [3:0] rx_nib_in;
  logic [4:0] ch_idx;
  logic [2:0] bit_idx;
  logic [3:0] tx_nib;
  logic [4:0] tx_nib_ch;
  logic       tx_nib_vld, rx_sig_out;

  always #4 clk = ~clk;

  sigbus_port u_sigbus_port (
    .clk(clk), .rst_n(rst_n), .frac_en(frac_en), .frame_start(frame_start),
    .tx_sig_in(tx_sig_in), .rx_nib_in(rx_nib_in), .ch_idx(ch_idx), .bit_idx(bit_idx),
    .tx_nib(tx_nib), .tx_nib_ch(tx_nib_ch), .tx_nib_vld(tx_nib_vld), .rx_sig_out(rx_sig_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench's own position model and pending strobe expectation.
  int         m_bit, m_ch, exp_ch;
  bit         exp_vld;
  logic [3:0] exp_nib;

  function automatic logic [3:0] pat_tx(input int ch, input int salt);
    return 4'((ch * 7 + salt * 5 + 3) % 16);
  endfunction

  function automatic logic [3:0] pat_rx(input int ch, input int salt);
    return 4'((ch * 11 + salt * 3 + 9) % 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic step(input bit fs, input bit en, input int salt);
    logic [3:0] tn, rn;
    logic       exp_rx;
    if (fs) begin m_bit = 0; m_ch = 0; end
    tn = pat_tx(m_ch, salt);
    rn = pat_rx(m_ch, salt);
    frame_start = fs;
    frac_en     = en;
    rx_nib_in   = rn;
    // Head bits carry the inverted nibble so a leak corrupts captures (R5).
    tx_sig_in   = (m_bit >= 4) ? tn[7 - m_bit] : ~tn[3 - m_bit];
    #1;
    chk(bit_idx == 3'(m_bit), fs ? "R3 bit_idx" : "R2 bit_idx", int'(bit_idx), m_bit);
    chk(ch_idx == 5'(m_ch), fs ? "R3 ch_idx" : "R2 ch_idx", int'(ch_idx), m_ch);
    exp_rx = en ? ((m_bit < 4) ? 1'b0 : rn[7 - m_bit]) : (m_bit == 0);
    chk(rx_sig_out == exp_rx, !en ? "R9 marker" : ((m_bit < 4) ? "R6 head" : "R7 sig"),
        int'(rx_sig_out), int'(exp_rx));
    chk(tx_nib_vld == exp_vld, "R4 R8 R9 strobe", int'(tx_nib_vld), int'(exp_vld));
    if (exp_vld && tx_nib_vld) begin
      chk(tx_nib == exp_nib, "R4 R5 nibble", int'(tx_nib), int'(exp_nib));
      chk(tx_nib_ch == 5'(exp_ch), "R4 channel", int'(tx_nib_ch), exp_ch);
    end
    exp_vld = en && (m_bit == 7);
    exp_nib = tn;
    exp_ch  = m_ch;
    m_bit++;
    if (m_bit == 8) begin
      m_bit = 0;
      m_ch  = (m_ch + 1) % 32;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frac_en = 1'b1; frame_start = 1'b0; tx_sig_in = 1'b1; rx_nib_in = 4'hF;
    m_bit = 0; m_ch = 0; exp_vld = 0; exp_nib = '0; exp_ch = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(ch_idx == 5'd0, "R1 ch_idx", int'(ch_idx), 0);
    chk(bit_idx == 3'd0, "R1 bit_idx", int'(bit_idx), 0);
    chk(tx_nib_vld == 1'b0, "R1 strobe", int'(tx_nib_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // First cycle after release is covered by step() (R1 position and strobe).
    // Two aligned frames, all channels, distinct nibble sets.
    for (int f = 0; f < 2; f++)
      for (int k = 0; k < 256; k++) step(f == 0 && k == 0, 1'b1, f);
    // Restart inside channel 5's signaling window (R8).
    for (int k = 0; k < 5 * 8 + 5; k++) step(1'b0, 1'b1, 2);
    step(1'b1, 1'b1, 3);
    // Free run across the frame end with no frame start (R2 wrap).
    for (int k = 0; k < 300; k++) step(1'b0, 1'b1, 3);
    // Fractional mode off for a full frame, then back on mid-octet (R9).
    for (int k = 0; k < 256; k++) step(1'b0, 1'b0, 4);
    for (int k = 0; k < 100; k++) step(1'b0, 1'b1, 4);
    done = 1;
    report();
    $finish;
  end

endmodule